// File: doc/BRIEF.md
# Retro Microcomputer Address Decoder with Floating Bus

This block sits between an 8-bit CPU and the memory-mapped devices of a small retro microcomputer. On each read or write it looks at the 16-bit CPU address and routes the access to exactly one target. The targets are main RAM, the motherboard soft-switch page, the per-slot card ROMs, the shared expansion ROM window, and the high region. In the high region a card bank handler and the motherboard ROM compete for the bus. Each target gets a select, a write enable where writes apply, and an offset local to its region. Each target also returns read data on its own input.

The block also models a data bus that nothing pulls to a fixed level. A register keeps the last byte that appeared on the bus. That value goes out to every target as `bus_val`, so a target that drives only some data bits can pass the rest through unchanged. A read cycle that selects nothing returns the held byte. A write puts the CPU's write data on the bus, and the register captures it.

Top module: `retro_addr_decoder`

## Requirements
- R1: An access with address bits 15:14 not both 1 (below 0xC000) asserts `ram_sel`, with `ram_off` equal to the address. `ram_we` is high only on writes. A read returns `ram_rdata` on `cpu_rdata` in the same cycle.
- R2: An access in 0xC000–0xC0FF asserts `sw_sel` with `sw_off` equal to address bits 7:0. `sw_we` is high on writes. A read returns `sw_rdata`.
- R3: A read in 0xC100–0xC7FF asserts `slot_sel`. `slot_num` equals address bits 10:8 (1 to 7) and `slot_off` equals address bits 7:0. The read returns `slot_rdata`.
- R4: A read in 0xC800–0xCFFF (I/O region with bit 11 set) asserts `xrom_sel` with the 11-bit `xrom_off` equal to address bits 10:0. The read returns `xrom_rdata`.
- R5: A write in 0xC100–0xCFFF asserts no select and no write enable. At most one of `ram_sel`, `sw_sel`, `slot_sel`, `xrom_sel`, `card_sel` is high in any cycle.
- R6: An access in 0xD000–0xFFFF asserts `card_sel` with `card_off` = address − 0xD000. `card_we` is high on writes, and writes go to no other target.
- R7: A read in 0xD000–0xFFFF with `card_inhibit` low asserts `rom_sel`, with `rom_off` = address − 0xD000, and returns `rom_rdata`. With `card_inhibit` high, `rom_sel` stays low and the read returns `card_rdata`.
- R8: The bus register resets to 0xFF. At the end of every read cycle it loads the byte returned on `cpu_rdata`. During reads and idle cycles, `bus_val` shows the held value.
- R9: During a write, `bus_val` and `cpu_rdata` both equal `cpu_wdata` in the same cycle, and the bus register loads `cpu_wdata`. When `cpu_rd` and `cpu_wr` are both high, the cycle is handled as a write.
- R10: With neither strobe high, no select is asserted, `cpu_rdata` equals the held bus value, and the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one access per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Byte returned to the CPU |
| bus_val | output | 8 | Current bus byte, offered to every target |
| ram_sel | output | 1 | Main RAM select |
| ram_we | output | 1 | Main RAM write enable |
| ram_off | output | 16 | Main RAM address |
| ram_rdata | input | 8 | Main RAM read data |
| sw_sel | output | 1 | Soft-switch page select |
| sw_we | output | 1 | Soft-switch write enable |
| sw_off | output | 8 | Soft-switch offset |
| sw_rdata | input | 8 | Soft-switch read data |
| slot_sel | output | 1 | Slot ROM select (reads only) |
| slot_num | output | 3 | Slot number 1–7 |
| slot_off | output | 8 | Offset in the slot ROM |
| slot_rdata | input | 8 | Slot ROM read data |
| xrom_sel | output | 1 | Shared expansion ROM select (reads only) |
| xrom_off | output | 11 | Expansion ROM offset |
| xrom_rdata | input | 8 | Expansion ROM read data |
| card_sel | output | 1 | Card bank handler select |
| card_we | output | 1 | Card bank handler write enable |
| card_off | output | 14 | Offset from 0xD000 |
| card_rdata | input | 8 | Card bank handler read data |
| card_inhibit | input | 1 | A card takes the high region from the motherboard ROM |
| rom_sel | output | 1 | Motherboard ROM select (reads only) |
| rom_off | output | 14 | Motherboard ROM offset from 0xD000 |
| rom_rdata | input | 8 | Motherboard ROM read data |

## Verification
Selects, write enables, offsets, `cpu_rdata` and, during writes, `bus_val` are combinational, so they are due in the same cycle as the address and strobes. The bench drives each access on the falling clock edge and samples these outputs a quarter period later, before the next rising edge. The bus register changes one rising edge after the access. It is checked through `bus_val` in the sampling window of the following non-write cycle. The expected value is kept in a bench-side byte that is updated from the requirement rules.

// File: rtl/retro_addr_decoder.sv
module retro_addr_decoder #(
  parameter int DW = 8,
  parameter logic [DW-1:0] BUS_INIT = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic [DW-1:0] bus_val,
  output logic          ram_sel,
  output logic          ram_we,
  output logic [15:0]   ram_off,
  input  logic [DW-1:0] ram_rdata,
  output logic          sw_sel,
  output logic          sw_we,
  output logic [7:0]    sw_off,
  input  logic [DW-1:0] sw_rdata,
  output logic          slot_sel,
  output logic [2:0]    slot_num,
  output logic [7:0]    slot_off,
  input  logic [DW-1:0] slot_rdata,
  output logic          xrom_sel,
  output logic [10:0]   xrom_off,
  input  logic [DW-1:0] xrom_rdata,
  output logic          card_sel,
  output logic          card_we,
  output logic [13:0]   card_off,
  input  logic [DW-1:0] card_rdata,
  input  logic          card_inhibit,
  output logic          rom_sel,
  output logic [13:0]   rom_off,
  input  logic [DW-1:0] rom_rdata
);
  localparam logic [15:0] HI_BASE = 16'hD000;
  localparam logic [3:0]  IO_PAGE = 4'hC;

  logic [DW-1:0] bus_q;
  logic          act, rd_op, wr_op;
  logic          in_ram, in_io, in_hi, sw_hit, slot_hit, xrom_hit;
  logic [15:0]   hi_rel;

  assign wr_op = cpu_wr;
  assign rd_op = cpu_rd & ~cpu_wr;
  assign act   = cpu_rd | cpu_wr;

  assign in_ram   = ~(cpu_addr[15] & cpu_addr[14]);
  assign in_io    = cpu_addr[15:12] == IO_PAGE;
  assign in_hi    = ~in_ram & ~in_io;
  assign sw_hit   = in_io & ~cpu_addr[11] & (cpu_addr[10:8] == 3'd0);
  assign slot_hit = in_io & ~cpu_addr[11] & (cpu_addr[10:8] != 3'd0);
  assign xrom_hit = in_io & cpu_addr[11];

  assign ram_sel  = act & in_ram;
  assign ram_we   = wr_op & in_ram;
  assign sw_sel   = act & sw_hit;
  assign sw_we    = wr_op & sw_hit;
  assign slot_sel = rd_op & slot_hit;
  assign xrom_sel = rd_op & xrom_hit;
  assign card_sel = act & in_hi;
  assign card_we  = wr_op & in_hi;
  assign rom_sel  = rd_op & in_hi & ~card_inhibit;

  assign hi_rel   = cpu_addr - HI_BASE;
  assign ram_off  = cpu_addr;
  assign sw_off   = cpu_addr[7:0];
  assign slot_num = cpu_addr[10:8];
  assign slot_off = cpu_addr[7:0];
  assign xrom_off = cpu_addr[10:0];
  assign card_off = hi_rel[13:0];
  assign rom_off  = hi_rel[13:0];

  assign bus_val  = wr_op ? cpu_wdata : bus_q;

  always_comb begin
    cpu_rdata = bus_val;
    if (rd_op) begin
      if (in_ram)        cpu_rdata = ram_rdata;
      else if (sw_hit)   cpu_rdata = sw_rdata;
      else if (slot_hit) cpu_rdata = slot_rdata;
      else if (xrom_hit) cpu_rdata = xrom_rdata;
      else               cpu_rdata = card_inhibit ? card_rdata : rom_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   bus_q <= BUS_INIT;
    else if (act) bus_q <= cpu_rdata;
  end

  a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, sw_sel, slot_sel, xrom_sel, card_sel}));

  a_r5_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> !slot_sel && !xrom_sel && !rom_sel);

  a_r7_rom_yields: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> card_sel && !card_inhibit);

  a_r8_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr) |=> bus_val == $past(cpu_rdata) || cpu_wr);

  a_r9_write_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> bus_q == $past(cpu_wdata));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd && !cpu_wr) |=> $stable(bus_q));
endmodule

// File: tb/tb_retro_addr_decoder.sv
module tb_retro_addr_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0, card_inhibit = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata, bus_val;
  logic ram_sel, ram_we, sw_sel, sw_we, slot_sel, xrom_sel, card_sel, card_we, rom_sel;
  logic [15:0] ram_off;
  logic [7:0] sw_off, slot_off;
  logic [2:0] slot_num;
  logic [10:0] xrom_off;
  logic [13:0] card_off, rom_off;
  logic [7:0] ram_rdata = 8'h11, sw_rdata = 8'h22, slot_rdata = 8'h33;
  logic [7:0] xrom_rdata = 8'h44, card_rdata = 8'h55, rom_rdata = 8'h66;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  retro_addr_decoder dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bus_val(bus_val),
    .ram_sel(ram_sel), .ram_we(ram_we), .ram_off(ram_off), .ram_rdata(ram_rdata),
    .sw_sel(sw_sel), .sw_we(sw_we), .sw_off(sw_off), .sw_rdata(sw_rdata),
    .slot_sel(slot_sel), .slot_num(slot_num), .slot_off(slot_off), .slot_rdata(slot_rdata),
    .xrom_sel(xrom_sel), .xrom_off(xrom_off), .xrom_rdata(xrom_rdata),
    .card_sel(card_sel), .card_we(card_we), .card_off(card_off), .card_rdata(card_rdata),
    .card_inhibit(card_inhibit), .rom_sel(rom_sel), .rom_off(rom_off), .rom_rdata(rom_rdata)
  );

  // {rd, wr, inhibit, sel{ram,sw,slot,xrom,card,rom}, addr, expected offset}
  localparam int NV = 16;
  localparam logic [40:0] VEC [NV] = '{
    {3'b100, 6'b100000, 16'h0000, 16'h0000},  // R1
    {3'b100, 6'b100000, 16'hBFFF, 16'hBFFF},  // R1
    {3'b010, 6'b100000, 16'h1234, 16'h1234},  // R1 R9
    {3'b100, 6'b010000, 16'hC000, 16'h0000},  // R2
    {3'b010, 6'b010000, 16'hC0FF, 16'h00FF},  // R2 R9
    {3'b100, 6'b001000, 16'hC100, 16'h0100},  // R3
    {3'b100, 6'b001000, 16'hC7FF, 16'h07FF},  // R3
    {3'b010, 6'b000000, 16'hC300, 16'h0000},  // R5
    {3'b100, 6'b000100, 16'hC800, 16'h0000},  // R4
    {3'b100, 6'b000100, 16'hCFFF, 16'h07FF},  // R4
    {3'b010, 6'b000000, 16'hCABC, 16'h0000},  // R5
    {3'b100, 6'b000011, 16'hD000, 16'h0000},  // R6 R7
    {3'b101, 6'b000010, 16'hFFFF, 16'h2FFF},  // R7 inhibit
    {3'b010, 6'b000010, 16'hE000, 16'h1000},  // R6 write
    {3'b000, 6'b000000, 16'h0000, 16'h0000},  // R10 idle
    {3'b110, 6'b100000, 16'h0040, 16'h0040}   // R9 rd+wr
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic wr, input logic [5:0] s,
                                        input logic [7:0] wd, input logic [7:0] held);
    if (wr)        return wd;
    if (s[0])      return 8'h66;
    if (s[1])      return 8'h55;
    if (s[5])      return 8'h11;
    if (s[4])      return 8'h22;
    if (s[3])      return 8'h33;
    if (s[2])      return 8'h44;
    return held;
  endfunction

  function automatic string tag(input logic [5:0] s, input logic wr);
    if (s[5]) return "R1";
    if (s[4]) return "R2";
    if (s[3]) return "R3";
    if (s[2]) return "R4";
    if (s[0] || (s[1] && !wr)) return "R7";
    if (s[1]) return "R6";
    if (wr)   return "R5";
    return "R10";
  endfunction

  logic [7:0] exp_bus;

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    exp_bus = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R8 reset bus", {8'h0, bus_val}, 16'h00FF);
    check("R10 reset rdata", {8'h0, cpu_rdata}, 16'h00FF);
    check("R10 reset sel", {10'h0, ram_sel, sw_sel, slot_sel, xrom_sel, card_sel, rom_sel}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic rd, wr, inh;
      logic [5:0] s;
      logic [15:0] a, off, got_off;
      logic [7:0] wd, er;
      string t;
      {rd, wr, inh, s, a, off} = VEC[i];
      wd = a[7:0] ^ 8'h5A;
      t = tag(s, wr);
      @(negedge clk);
      cpu_rd = rd; cpu_wr = wr; card_inhibit = inh; cpu_addr = a; cpu_wdata = wd;
      #5;
      if (!wr) check("R8 held bus", {8'h0, bus_val}, {8'h0, exp_bus});
      check({t, " select"}, {10'h0, ram_sel, sw_sel, slot_sel, xrom_sel, card_sel, rom_sel}, {10'h0, s});
      check({t, " write enable"}, {13'h0, ram_we, sw_we, card_we}, {13'h0, s[5] & wr, s[4] & wr, s[1] & wr});
      got_off = 16'h0;
      if (s[5]) got_off = ram_off;
      else if (s[4]) got_off = {8'h0, sw_off};
      else if (s[3]) got_off = {5'h0, slot_num, slot_off};
      else if (s[2]) got_off = {5'h0, xrom_off};
      else if (s[1]) got_off = {2'h0, card_off};
      check({t, " offset"}, got_off, off);
      if (s[0]) check("R7 rom offset", {2'h0, rom_off}, off);
      er = exp_rd(wr, s, wd, exp_bus);
      check({t, " rdata"}, {8'h0, cpu_rdata}, {8'h0, er});
      if (wr) check("R9 bus drive", {8'h0, bus_val}, {8'h0, wd});
      if (rd || wr) exp_bus = er;
    end

    // R10: idle after the table keeps the written byte on the bus
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    #5;
    check("R10 idle bus", {8'h0, bus_val}, {8'h0, exp_bus});
    @(negedge clk);
    #5;
    check("R10 idle hold", {8'h0, cpu_rdata}, {8'h0, exp_bus});

    // R7: floating read through an inhibiting card that returns the bus byte
    @(negedge clk);
    card_rdata = bus_val;
    cpu_rd = 1'b1; cpu_addr = 16'hF800; card_inhibit = 1'b1;
    #5;
    check("R7 inhibit float", {8'h0, cpu_rdata}, {8'h0, exp_bus});
    check("R7 rom blocked", {15'h0, rom_sel}, 16'h0);

    // R8: reset mid-run brings the register back to 0xFF
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_addr = 16'h0100; cpu_wdata = 8'h00;
    @(negedge clk);
    cpu_wr = 1'b0; rst_n = 1'b0;
    #5;
    check("R9 written zero", {8'h0, bus_val}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R8 reset again", {8'h0, bus_val}, 16'h00FF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule